// File: doc/BRIEF.md
# DMA Channel Address Generator

This block produces the byte address of every element that one DMA channel moves, on the read side and on the write side. A transfer is a block made of a number of frames, and each frame holds a number of elements. Both counts, the element size and the two start addresses are taken in by a single load strobe. From then on each element handshake moves both addresses forward and counts the element off.

Each side has its own addressing mode, chosen from four. The address can stay fixed, step by the element size, step by a signed element index, or step by a signed element index inside a frame and by a signed frame index across a frame boundary. A compatibility option makes the write side use the read side's indices. Pulses mark each element, the half-way point of a frame, the end of a frame, the start of the final frame and the end of the block.

A small data path sits beside the address logic. It can replace the read data with a programmed 32-bit color and drop the read, or it can suppress writes whose data equals that color.

Top module: `dma_addr_gen`

## Requirements
- R1: After reset `busy` is 0, both addresses are 0 and no event, read enable or write enable is asserted.
- R2: A `load` pulse with nonzero element and frame counts sets `busy` in the next cycle and presents the start addresses. If either count is zero, `busy` stays 0 and no element is accepted.
- R3: The element size is 1, 2 or 4 bytes for size code 0, 1 or 2. Code 3 also gives 4 bytes.
- R4: In mode 0 (constant) a side's address does not change on handshakes.
- R5: In mode 1 (post-increment) a side's address grows by the element size after every accepted element.
- R6: In mode 2 (single index) each accepted element adds element size + element index − 1 to the address. The index is taken as a 16-bit two's-complement value.
- R7: In mode 3 (double index) each accepted element inside a frame adds the same step as mode 2. The last element of a frame instead adds element size + frame index − 1.
- R8: With `cfg_legacy` set at load, the write side uses the read side's element and frame indices. The write-side index inputs are then ignored.
- R9: `ev_half` pulses on the handshake that brings the elements completed in the current frame to floor(E/2). It never pulses when E is 1.
- R10: `ev_frame_end` pulses on the last element of every frame. `ev_last_frame` pulses when the final frame begins: on the load of a one-frame block, or on the handshake that ends the second-to-last frame.
- R11: `ev_block_end` pulses in the cycle of the final handshake, and `busy` is 0 from the next cycle. While `busy` is 0, `elem_ack` changes neither addresses nor events. A handshake in a `load` cycle is not counted.
- R12: With constant fill latched, `wr_data` is the color value and `rd_en` stays 0. Otherwise `wr_data` is `rd_data` and `rd_en` equals `busy`.
- R13: With transparent copy latched, `wr_en` stays 0 on a handshake whose write data equals the color. Otherwise `wr_en` pulses on every accepted element.
- R14: Configuration inputs that change after the load cycle have no effect on the running block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load | input | 1 | Latch the configuration and restart the block |
| cfg_src_addr | input | 32 | Read-side start address |
| cfg_dst_addr | input | 32 | Write-side start address |
| cfg_elem_cnt | input | 16 | Elements per frame |
| cfg_frame_cnt | input | 16 | Frames per block |
| cfg_size_code | input | 2 | Element size code |
| cfg_src_mode | input | 2 | Read-side addressing mode |
| cfg_dst_mode | input | 2 | Write-side addressing mode |
| cfg_src_eidx | input | 16 | Read-side signed element index |
| cfg_src_fidx | input | 16 | Read-side signed frame index |
| cfg_dst_eidx | input | 16 | Write-side signed element index |
| cfg_dst_fidx | input | 16 | Write-side signed frame index |
| cfg_legacy | input | 1 | Write side uses read-side indices |
| cfg_fill | input | 1 | Constant-fill enable |
| cfg_transp | input | 1 | Transparent-copy enable |
| cfg_color | input | 32 | Fill / transparency color |
| elem_ack | input | 1 | Current element transferred |
| rd_data | input | 32 | Data read for the current element |
| busy | output | 1 | Block in progress |
| src_addr | output | 32 | Read address of the current element |
| dst_addr | output | 32 | Write address of the current element |
| rd_en | output | 1 | A read is needed for the current element |
| wr_en | output | 1 | Perform the write on this handshake |
| wr_data | output | 32 | Data to write |
| ev_elem | output | 1 | Element accepted |
| ev_half | output | 1 | Half of the frame's elements done |
| ev_frame_end | output | 1 | Last element of a frame |
| ev_last_frame | output | 1 | Final frame begins |
| ev_block_end | output | 1 | Last element of the block |

## Verification
The hardest case to reach is a double-index frame wrap on the write side in compatibility mode. There, the step has to come from the read-side frame index while the write-side index inputs carry different, misleading values. Random blocks use small element and frame counts, so frame wraps happen often. Each block draws modes, indices and the compatibility flag independently, and the configuration inputs are scrambled on every cycle after the load. This drives the wrap, the half-frame threshold and the final-frame handoff through many combinations of a reference model.

// File: rtl/dma_agen_pkg.sv
// Shared types and helpers for the DMA channel address generator.
// Assumes byte addressing and a 2-bit element size code.
package dma_agen_pkg;

    typedef enum logic [1:0] {
        AM_CONST  = 2'd0,
        AM_POST   = 2'd1,
        AM_SINGLE = 2'd2,
        AM_DOUBLE = 2'd3
    } addr_mode_e;

    // Element size in bytes for a size code; code 3 saturates at 4 bytes.
    function automatic logic [2:0] elem_bytes(input logic [1:0] code);
        case (code)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/agen_stepper.sv
// Address stepper for one side of the channel.
// Latches start address, mode and indices on load; on each accepted
// element adds the step selected by the mode. Assumes adv never
// coincides with load (the top gates it).
module agen_stepper
    import dma_agen_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [1:0]        mode_in,
    input  logic [IDX_W-1:0]  eidx_in,
    input  logic [IDX_W-1:0]  fidx_in,
    input  logic [2:0]        size_bytes,
    input  logic              adv,
    input  logic              frame_wrap,
    output logic [ADDR_W-1:0] addr
);
    localparam int EXT_W = ADDR_W - IDX_W;

    addr_mode_e        mode_q;
    logic [IDX_W-1:0]  eidx_q;
    logic [IDX_W-1:0]  fidx_q;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] size_ext;
    logic [ADDR_W-1:0] eidx_ext;
    logic [ADDR_W-1:0] fidx_ext;
    logic [ADDR_W-1:0] step;

    // Hold the per-side programming for the duration of the block.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= AM_CONST;
            eidx_q <= '0;
            fidx_q <= '0;
        end else if (load) begin
            mode_q <= addr_mode_e'(mode_in);
            eidx_q <= eidx_in;
            fidx_q <= fidx_in;
        end
    end

    // Sign-extend the indices and widen the element size.
    always_comb begin
        size_ext = ADDR_W'(size_bytes);
        eidx_ext = {{EXT_W{eidx_q[IDX_W-1]}}, eidx_q};
        fidx_ext = {{EXT_W{fidx_q[IDX_W-1]}}, fidx_q};
    end

    // Select the increment for the element just accepted.
    always_comb begin
        case (mode_q)
            AM_CONST:  step = '0;
            AM_POST:   step = size_ext;
            AM_SINGLE: step = size_ext + eidx_ext - ADDR_W'(1);
            default:   step = frame_wrap ? (size_ext + fidx_ext - ADDR_W'(1))
                                         : (size_ext + eidx_ext - ADDR_W'(1));
        endcase
    end

    // Address register: reload on load, advance on an accepted element.
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr_q <= '0;
        else if (load)
            addr_q <= start_addr;
        else if (adv)
            addr_q <= addr_q + step;
    end

    assign addr = addr_q;

endmodule

// File: rtl/agen_counter.sv
// Element and frame down-counters with event decode.
// Latches the counts on load; busy only when both are nonzero.
// Events are combinational on the handshake cycle.
module agen_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] elem_cnt,
    input  logic [CNT_W-1:0] frame_cnt,
    input  logic             elem_ack,
    output logic             busy,
    output logic             accept,
    output logic             frame_wrap,
    output logic             ev_half,
    output logic             ev_last_frame,
    output logic             ev_block_end
);
    localparam int HW = CNT_W + 1;

    logic [CNT_W-1:0] elems_q;
    logic [CNT_W-1:0] erem_q;
    logic [CNT_W-1:0] frem_q;
    logic             busy_q;
    logic [HW-1:0]    half_mark;
    logic             load_ok;

    assign load_ok = (elem_cnt != '0) && (frame_cnt != '0);
    assign accept  = busy_q && elem_ack && !load;

    // Count elements and frames down; drop busy after the final element.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            elems_q <= '0;
            erem_q  <= '0;
            frem_q  <= '0;
            busy_q  <= 1'b0;
        end else if (load) begin
            elems_q <= elem_cnt;
            erem_q  <= elem_cnt;
            frem_q  <= frame_cnt;
            busy_q  <= load_ok;
        end else if (accept) begin
            if (erem_q == CNT_W'(1)) begin
                erem_q <= elems_q;
                if (frem_q == CNT_W'(1))
                    busy_q <= 1'b0;
                else
                    frem_q <= frem_q - CNT_W'(1);
            end else begin
                erem_q <= erem_q - CNT_W'(1);
            end
        end
    end

    // Remaining-count value at which half of the frame completes.
    always_comb begin
        half_mark = HW'(elems_q) - HW'(elems_q >> 1) + HW'(1);
    end

    // Decode the events of the current handshake.
    always_comb begin
        frame_wrap    = accept && (erem_q == CNT_W'(1));
        ev_block_end  = frame_wrap && (frem_q == CNT_W'(1));
        ev_half       = accept && (elems_q >= CNT_W'(2)) && (HW'(erem_q) == half_mark);
        ev_last_frame = (load && load_ok && (frame_cnt == CNT_W'(1))) ||
                        (frame_wrap && (frem_q == CNT_W'(2)));
    end

    assign busy = busy_q;

endmodule

// File: rtl/agen_datapath.sv
// Fill and transparency data path.
// Latches the fill, transparency and color settings on load; picks
// the write data and decides whether the write happens.
module agen_datapath #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              fill_in,
    input  logic              transp_in,
    input  logic [DATA_W-1:0] color_in,
    input  logic              busy,
    input  logic              accept,
    input  logic [DATA_W-1:0] rd_data,
    output logic              rd_en,
    output logic              wr_en,
    output logic [DATA_W-1:0] wr_data
);
    logic              fill_q;
    logic              transp_q;
    logic [DATA_W-1:0] color_q;

    // Capture the data-path options for the block.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_q   <= 1'b0;
            transp_q <= 1'b0;
            color_q  <= '0;
        end else if (load) begin
            fill_q   <= fill_in;
            transp_q <= transp_in;
            color_q  <= color_in;
        end
    end

    // Choose write data and qualify read and write.
    always_comb begin
        wr_data = fill_q ? color_q : rd_data;
        rd_en   = busy && !fill_q;
        wr_en   = accept && !(transp_q && (wr_data == color_q));
    end

endmodule

// File: rtl/dma_addr_gen.sv
// DMA channel address generator top.
// Selects per-side configuration (with the index-sharing option),
// latches the element size, and ties the counter, both steppers and
// the data path together. Assumes load is a one-cycle strobe.
module dma_addr_gen
    import dma_agen_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int IDX_W  = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] cfg_src_addr,
    input  logic [ADDR_W-1:0] cfg_dst_addr,
    input  logic [CNT_W-1:0]  cfg_elem_cnt,
    input  logic [CNT_W-1:0]  cfg_frame_cnt,
    input  logic [1:0]        cfg_size_code,
    input  logic [1:0]        cfg_src_mode,
    input  logic [1:0]        cfg_dst_mode,
    input  logic [IDX_W-1:0]  cfg_src_eidx,
    input  logic [IDX_W-1:0]  cfg_src_fidx,
    input  logic [IDX_W-1:0]  cfg_dst_eidx,
    input  logic [IDX_W-1:0]  cfg_dst_fidx,
    input  logic              cfg_legacy,
    input  logic              cfg_fill,
    input  logic              cfg_transp,
    input  logic [DATA_W-1:0] cfg_color,
    input  logic              elem_ack,
    input  logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic [ADDR_W-1:0] src_addr,
    output logic [ADDR_W-1:0] dst_addr,
    output logic              rd_en,
    output logic              wr_en,
    output logic [DATA_W-1:0] wr_data,
    output logic              ev_elem,
    output logic              ev_half,
    output logic              ev_frame_end,
    output logic              ev_last_frame,
    output logic              ev_block_end
);
    localparam int NSIDE = 2;

    logic [1:0]        size_code_q;
    logic [2:0]        size_bytes;
    logic              accept;
    logic              frame_wrap;
    logic [ADDR_W-1:0] side_start [NSIDE];
    logic [1:0]        side_mode  [NSIDE];
    logic [IDX_W-1:0]  side_eidx  [NSIDE];
    logic [IDX_W-1:0]  side_fidx  [NSIDE];
    logic [ADDR_W-1:0] side_addr  [NSIDE];

    // Latch the element size code for the block.
    always_ff @(posedge clk) begin
        if (!rst_n)
            size_code_q <= '0;
        else if (load)
            size_code_q <= cfg_size_code;
    end

    assign size_bytes = elem_bytes(size_code_q);

    // Route configuration to each side; shared indices in legacy mode.
    always_comb begin
        side_start[0] = cfg_src_addr;
        side_mode[0]  = cfg_src_mode;
        side_eidx[0]  = cfg_src_eidx;
        side_fidx[0]  = cfg_src_fidx;
        side_start[1] = cfg_dst_addr;
        side_mode[1]  = cfg_dst_mode;
        side_eidx[1]  = cfg_legacy ? cfg_src_eidx : cfg_dst_eidx;
        side_fidx[1]  = cfg_legacy ? cfg_src_fidx : cfg_dst_fidx;
    end

    agen_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk           (clk),
        .rst_n         (rst_n),
        .load          (load),
        .elem_cnt      (cfg_elem_cnt),
        .frame_cnt     (cfg_frame_cnt),
        .elem_ack      (elem_ack),
        .busy          (busy),
        .accept        (accept),
        .frame_wrap    (frame_wrap),
        .ev_half       (ev_half),
        .ev_last_frame (ev_last_frame),
        .ev_block_end  (ev_block_end)
    );

    for (genvar s = 0; s < NSIDE; s++) begin : g_side
        agen_stepper #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_step (
            .clk        (clk),
            .rst_n      (rst_n),
            .load       (load),
            .start_addr (side_start[s]),
            .mode_in    (side_mode[s]),
            .eidx_in    (side_eidx[s]),
            .fidx_in    (side_fidx[s]),
            .size_bytes (size_bytes),
            .adv        (accept),
            .frame_wrap (frame_wrap),
            .addr       (side_addr[s])
        );
    end

    agen_datapath #(.DATA_W(DATA_W)) u_data (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .fill_in   (cfg_fill),
        .transp_in (cfg_transp),
        .color_in  (cfg_color),
        .busy      (busy),
        .accept    (accept),
        .rd_data   (rd_data),
        .rd_en     (rd_en),
        .wr_en     (wr_en),
        .wr_data   (wr_data)
    );

    assign src_addr     = side_addr[0];
    assign dst_addr     = side_addr[1];
    assign ev_elem      = accept;
    assign ev_frame_end = frame_wrap;

endmodule

// File: rtl/agen_checker.sv
// Property checker for dma_addr_gen, bound to every instance.
// Keeps its own copy of the load-time settings it needs.
module agen_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        load,
    input logic [15:0] cfg_elem_cnt,
    input logic [15:0] cfg_frame_cnt,
    input logic [1:0]  cfg_size_code,
    input logic [1:0]  cfg_src_mode,
    input logic        cfg_fill,
    input logic        cfg_transp,
    input logic [31:0] cfg_color,
    input logic        elem_ack,
    input logic        busy,
    input logic [31:0] src_addr,
    input logic        rd_en,
    input logic        wr_en,
    input logic [31:0] wr_data,
    input logic        ev_elem,
    input logic        ev_frame_end,
    input logic        ev_block_end
);
    logic [1:0]  mode_k;
    logic [1:0]  size_k;
    logic        fill_k;
    logic        transp_k;
    logic [31:0] color_k;
    logic [31:0] inc_k;

    // Shadow of the settings captured at load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_k   <= 2'd0;
            size_k   <= 2'd0;
            fill_k   <= 1'b0;
            transp_k <= 1'b0;
            color_k  <= '0;
        end else if (load) begin
            mode_k   <= cfg_src_mode;
            size_k   <= cfg_size_code;
            fill_k   <= cfg_fill;
            transp_k <= cfg_transp;
            color_k  <= cfg_color;
        end
    end

    assign inc_k = (size_k == 2'd0) ? 32'd1 : (size_k == 2'd1) ? 32'd2 : 32'd4;

    AST_ZERO_COUNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        load && (cfg_elem_cnt == 16'd0 || cfg_frame_cnt == 16'd0) |=> !busy); // R2
    AST_CONST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !load && elem_ack && mode_k == 2'd0 |=> $stable(src_addr)); // R4
    AST_POST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !load && elem_ack && mode_k == 2'd1 |=> src_addr == $past(src_addr) + $past(inc_k)); // R5
    AST_BLOCK_IS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        ev_block_end |-> ev_frame_end && ev_elem); // R10
    AST_BLOCK_END_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ev_block_end && !load |=> !busy); // R11
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !ev_elem && !wr_en); // R11
    AST_FILL_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        fill_k |-> !rd_en && wr_data == color_k); // R12
    AST_TRANSP_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && transp_k |-> wr_data != color_k); // R13

endmodule

bind dma_addr_gen agen_checker u_agen_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .load          (load),
    .cfg_elem_cnt  (cfg_elem_cnt),
    .cfg_frame_cnt (cfg_frame_cnt),
    .cfg_size_code (cfg_size_code),
    .cfg_src_mode  (cfg_src_mode),
    .cfg_fill      (cfg_fill),
    .cfg_transp    (cfg_transp),
    .cfg_color     (cfg_color),
    .elem_ack      (elem_ack),
    .busy          (busy),
    .src_addr      (src_addr),
    .rd_en         (rd_en),
    .wr_en         (wr_en),
    .wr_data       (wr_data),
    .ev_elem       (ev_elem),
    .ev_frame_end  (ev_frame_end),
    .ev_block_end  (ev_block_end)
);

// File: tb/tb_dma_addr_gen.sv
module tb_dma_addr_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load = 1'b0;
    logic [31:0] cfg_src_addr = '0, cfg_dst_addr = '0;
    logic [15:0] cfg_elem_cnt = '0, cfg_frame_cnt = '0;
    logic [1:0]  cfg_size_code = '0, cfg_src_mode = '0, cfg_dst_mode = '0;
    logic [15:0] cfg_src_eidx = '0, cfg_src_fidx = '0, cfg_dst_eidx = '0, cfg_dst_fidx = '0;
    logic        cfg_legacy = 1'b0, cfg_fill = 1'b0, cfg_transp = 1'b0;
    logic [31:0] cfg_color = '0;
    logic        elem_ack = 1'b0;
    logic [31:0] rd_data = '0;
    logic        busy, rd_en, wr_en, ev_elem, ev_half, ev_frame_end, ev_last_frame, ev_block_end;
    logic [31:0] src_addr, dst_addr, wr_data;

    always #4 clk = ~clk;   // 125 MHz

    dma_addr_gen dut (.*);

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // Configuration to apply at the next load
    logic [31:0] c_sa, c_da, c_color;
    logic [15:0] c_e, c_f, c_se, c_sf, c_de, c_df;
    logic [1:0]  c_code, c_sm, c_dm;
    logic        c_leg, c_fill, c_tr;

    // Reference model state
    logic        m_busy = 0;
    logic [31:0] m_src = 0, m_dst = 0, m_color = 0;
    logic [15:0] m_e = 0, m_r = 0, m_f = 0, m_se = 0, m_sf = 0, m_de = 0, m_df = 0;
    logic [1:0]  m_code = 0, m_sm = 0, m_dm = 0;
    logic        m_fill = 0, m_tr = 0, m_leg = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cycles);
        end
    endtask

    function automatic logic [31:0] bytes_of(input logic [1:0] code);
        return (code == 2'd0) ? 32'd1 : (code == 2'd1) ? 32'd2 : 32'd4;  // R3
    endfunction

    function automatic logic [31:0] sx(input logic [15:0] v);
        return {{16{v[15]}}, v};
    endfunction

    function automatic logic [31:0] model_step(input logic [1:0] mode, input logic [1:0] code,
                                               input logic [15:0] ei, input logic [15:0] fi, input bit wrap);
        logic [31:0] b = bytes_of(code);
        case (mode)
            2'd0: return 32'd0;                                  // R4
            2'd1: return b;                                      // R5
            2'd2: return b + sx(ei) - 32'd1;                     // R6
            default: return wrap ? b + sx(fi) - 32'd1 : b + sx(ei) - 32'd1; // R7
        endcase
    endfunction

    function automatic string tag_of(input logic [1:0] mode, input bit leg);
        if (leg) return "R8";
        case (mode)
            2'd0: return "R4";
            2'd1: return "R5";
            2'd2: return "R6";
            default: return "R7";
        endcase
    endfunction

    // One cycle: check registered outputs, drive inputs, check event outputs, update model.
    task automatic tick(input bit do_load, input bit ack, input logic [31:0] rdv, input bit scramble);
        bit acc, efe, ebe, ehalf, elast, ewr, erd;
        logic [31:0] ewd;
        @(negedge clk);
        chk(busy === m_busy, "R2/R11 busy", 32'(busy), 32'(m_busy));
        chk(src_addr === m_src, tag_of(m_sm, 1'b0), src_addr, m_src);
        chk(dst_addr === m_dst, tag_of(m_dm, m_leg), dst_addr, m_dst);
        load = do_load;
        elem_ack = ack;
        rd_data = rdv;
        if (do_load) begin
            cfg_src_addr = c_sa; cfg_dst_addr = c_da; cfg_elem_cnt = c_e; cfg_frame_cnt = c_f;
            cfg_size_code = c_code; cfg_src_mode = c_sm; cfg_dst_mode = c_dm;
            cfg_src_eidx = c_se; cfg_src_fidx = c_sf; cfg_dst_eidx = c_de; cfg_dst_fidx = c_df;
            cfg_legacy = c_leg; cfg_fill = c_fill; cfg_transp = c_tr; cfg_color = c_color;
        end else if (scramble) begin  // R14: changes after load must not matter
            cfg_src_addr = $urandom; cfg_dst_addr = $urandom;
            cfg_elem_cnt = 16'($urandom); cfg_frame_cnt = 16'($urandom);
            cfg_size_code = 2'($urandom); cfg_src_mode = 2'($urandom); cfg_dst_mode = 2'($urandom);
            cfg_src_eidx = 16'($urandom); cfg_src_fidx = 16'($urandom);
            cfg_dst_eidx = 16'($urandom); cfg_dst_fidx = 16'($urandom);
            cfg_legacy = 1'($urandom); cfg_fill = 1'($urandom); cfg_transp = 1'($urandom);
            cfg_color = $urandom;
        end
        #1;
        acc   = m_busy && ack && !do_load;
        efe   = acc && (m_r == 16'd1);
        ebe   = efe && (m_f == 16'd1);
        ehalf = acc && (m_e >= 16'd2) && ({1'b0, m_r} == {1'b0, m_e} - {1'b0, m_e >> 1} + 17'd1);
        elast = do_load ? (c_e != 0 && c_f == 16'd1) : (efe && m_f == 16'd2);
        ewd   = m_fill ? m_color : rdv;
        erd   = m_busy && !m_fill;
        ewr   = acc && !(m_tr && ewd == m_color);
        chk(ev_elem === acc, "R11 ev_elem", 32'(ev_elem), 32'(acc));
        chk(ev_frame_end === efe, "R10 ev_frame_end", 32'(ev_frame_end), 32'(efe));
        chk(ev_block_end === ebe, "R11 ev_block_end", 32'(ev_block_end), 32'(ebe));
        chk(ev_half === ehalf, "R9 ev_half", 32'(ev_half), 32'(ehalf));
        chk(ev_last_frame === elast, "R10 ev_last_frame", 32'(ev_last_frame), 32'(elast));
        chk(rd_en === erd, "R12 rd_en", 32'(rd_en), 32'(erd));
        chk(wr_data === ewd, "R12 wr_data", wr_data, ewd);
        chk(wr_en === ewr, "R13 wr_en", 32'(wr_en), 32'(ewr));
        if (do_load) begin
            m_busy = (c_e != 0) && (c_f != 0);
            m_src = c_sa; m_dst = c_da; m_e = c_e; m_r = c_e; m_f = c_f;
            m_code = c_code; m_sm = c_sm; m_dm = c_dm; m_leg = c_leg;
            m_se = c_se; m_sf = c_sf;
            m_de = c_leg ? c_se : c_de;
            m_df = c_leg ? c_sf : c_df;
            m_fill = c_fill; m_tr = c_tr; m_color = c_color;
        end else if (acc) begin
            m_src = m_src + model_step(m_sm, m_code, m_se, m_sf, efe);
            m_dst = m_dst + model_step(m_dm, m_code, m_de, m_df, efe);
            if (efe) begin
                m_r = m_e;
                if (ebe) m_busy = 0; else m_f = m_f - 16'd1;
            end else begin
                m_r = m_r - 16'd1;
            end
        end
    endtask

    task automatic rand_cfg();
        c_sa = $urandom; c_da = $urandom; c_color = $urandom;
        c_e = 16'($urandom_range(1, 6)); c_f = 16'($urandom_range(1, 4));
        c_code = 2'($urandom); c_sm = 2'($urandom); c_dm = 2'($urandom);
        c_se = 16'($signed($urandom_range(0, 40)) - 20);
        c_sf = 16'($signed($urandom_range(0, 40)) - 20);
        c_de = 16'($signed($urandom_range(0, 40)) - 20);
        c_df = 16'($signed($urandom_range(0, 40)) - 20);
        c_leg = ($urandom_range(0, 3) == 0);
        c_fill = ($urandom_range(0, 4) == 0);
        c_tr = ($urandom_range(0, 3) == 0);
    endtask

    task automatic run_block(input int ack_pct);
        tick(1'b1, 1'b1, $urandom, 1'b0);
        for (int k = 0; k < 300 && m_busy; k++) begin
            logic [31:0] d = ($urandom_range(0, 2) == 0) ? m_color : $urandom;
            tick(1'b0, $urandom_range(0, 99) < ack_pct, d, 1'b1);
        end
        // idle handshakes must change nothing (R11)
        tick(1'b0, 1'b1, $urandom, 1'b1);
        tick(1'b0, 1'b1, $urandom, 1'b1);
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // R1: reset state
        tick(1'b0, 1'b0, 32'h0, 1'b0);

        // R2: zero element count, zero frame count
        rand_cfg(); c_e = 16'd0; tick(1'b1, 1'b0, 0, 1'b0); tick(1'b0, 1'b1, 0, 1'b1);
        rand_cfg(); c_f = 16'd0; tick(1'b1, 1'b0, 0, 1'b0); tick(1'b0, 1'b1, 0, 1'b1);

        // R4/R5: constant read side, post-increment write side, 2-byte elements
        rand_cfg(); c_sm = 2'd0; c_dm = 2'd1; c_code = 2'd1; c_leg = 0; run_block(100);
        // R3: size code 3 behaves as 4 bytes
        rand_cfg(); c_sm = 2'd1; c_dm = 2'd1; c_code = 2'd3; run_block(80);
        // R7 + R8: double index with shared indices, misleading write-side indices
        rand_cfg(); c_sm = 2'd3; c_dm = 2'd3; c_leg = 1; c_de = 16'h7777; c_df = 16'h8001;
        c_e = 16'd4; c_f = 16'd3; run_block(90);
        // R9: one element per frame, half never fires; R10 single frame
        rand_cfg(); c_e = 16'd1; c_f = 16'd3; run_block(100);
        rand_cfg(); c_e = 16'd5; c_f = 16'd1; run_block(100);
        // R12: fill; R13: transparent
        rand_cfg(); c_fill = 1; c_tr = 0; run_block(100);
        rand_cfg(); c_fill = 0; c_tr = 1; run_block(100);
        // R11: reload in the middle of a block
        rand_cfg(); c_e = 16'd6; c_f = 16'd4; tick(1'b1, 1'b0, 0, 1'b0);
        for (int k = 0; k < 5; k++) tick(1'b0, 1'b1, $urandom, 1'b1);
        rand_cfg(); run_block(70);

        // Constrained random blocks (R6 and all others)
        for (int b = 0; b < 150; b++) begin
            rand_cfg();
            run_block($urandom_range(40, 100));
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule